// File: doc/BRIEF.md
# Single-Channel Block DMA Engine

This block moves block data between a card-side data buffer and system memory, one 32-bit word per memory beat. Software selects the direction and whether the memory address advances or stays put, writes a 64-bit start address as two 32-bit halves and sets a start bit. The engine then moves block size times block count bytes. When it stops, it raises a completion flag or an error flag, and each direction has its own pair.

The memory side is a request/grant port with one request outstanding and a separate response strobe that carries read data and an error indication. For card-to-memory transfers the buffer side is a valid/pop source. For memory-to-card transfers it is a ready/push sink. A reset register can stop either direction on its own.

Top module: `sdma_engine`

## Requirements
- R1: After reset, every register reads zero, the engine is idle and `mem_req`, `buf_rd_pop` and `buf_wr_push` are low.
- R2: Writing 1 to bit 0 of CTRL (word offset 1) starts a transfer. The bit reads 1 while a transfer runs and clears itself at the end. A start written while a transfer runs is ignored.
- R3: When bit 16 of MODE (offset 0) is 1, data moves card to memory. Each popped buffer word is written to memory (`mem_we`=1), and completion sets bit 20 of DONE (offset 3).
- R4: When MODE bit 16 is 0, data moves memory to card. Each memory read response is pushed to the buffer, and completion sets bit 16 of DONE.
- R5: When MODE bit 0 is 0 (fixed addressing), every beat uses the start address.
- R6: A transfer makes blk_size*blk_count/4 beats. A zero length sets the completion flag without any beat.
- R7: A start address whose low 4 bits are not zero makes no beat and sets the error flag of the selected direction: bit 17 of ERR (offset 4) for card-to-memory, bit 16 for memory-to-card. No completion flag is set.
- R8: A memory response with `mem_err` high ends the transfer after that beat. It sets the direction's error flag and leaves the completion flag clear.
- R9: In DONE and ERR, a write clears each flag whose written bit is 0 and keeps each flag whose written bit is 1.
- R10: Writing bit 9 of RST (offset 2) stops a running card-to-memory transfer and clears bits 20 of DONE and 17 of ERR. Bit 8 does the same for the memory-to-card side (bits 16). Neither bit affects a transfer in the other direction.
- R11: A memory request, once raised, holds its address and write flag until it is granted.
- R12: The start address is ADDR_LO (offset 5) and ADDR_HI (offset 6). With MODE bit 0 set, it advances by 4 per beat with full 64-bit carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| blk_size | input | 12 | Bytes per block |
| blk_count | input | 16 | Number of blocks |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Response strobe |
| mem_rdata | input | 32 | Read response data |
| mem_err | input | 1 | Response carries an error |
| buf_rd_valid | input | 1 | Card buffer has a word |
| buf_rd_data | input | 32 | Card buffer word |
| buf_rd_pop | output | 1 | Take one word from the card buffer |
| buf_wr_ready | input | 1 | Card buffer can take a word |
| buf_wr_data | output | 32 | Word for the card buffer |
| buf_wr_push | output | 1 | Place one word into the card buffer |

## Verification
The checks assume that the memory side never sends a response strobe without a granted request and never sends more than one response per grant. The bench's memory model answers exactly one cycle after each grant, so this always holds. Block sizes in the stimulus are multiples of 4, and software writes to the length inputs only while the engine is idle. The grant is sometimes withheld on alternate cycles so that the request-hold rule is exercised.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int RW      = 32;
  localparam int ADDR_W  = 2 * RW;
  localparam int OFS_W   = 3;

  localparam logic [OFS_W-1:0] OFS_MODE    = 3'd0;
  localparam logic [OFS_W-1:0] OFS_CTRL    = 3'd1;
  localparam logic [OFS_W-1:0] OFS_RST     = 3'd2;
  localparam logic [OFS_W-1:0] OFS_DONE    = 3'd3;
  localparam logic [OFS_W-1:0] OFS_ERR     = 3'd4;
  localparam logic [OFS_W-1:0] OFS_ADDR_LO = 3'd5;
  localparam logic [OFS_W-1:0] OFS_ADDR_HI = 3'd6;

  localparam int MODE_DIR_BIT = 16;
  localparam int MODE_INC_BIT = 0;
  localparam int CTRL_GO_BIT  = 0;
  localparam int RST_RD_BIT   = 9;
  localparam int RST_WR_BIT   = 8;
  localparam int DONE_RD_BIT  = 20;
  localparam int DONE_WR_BIT  = 16;
  localparam int ERR_RD_BIT   = 17;
  localparam int ERR_WR_BIT   = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_MREQ,
    ST_MRSP,
    ST_PUSH
  } xfer_st_e;
endpackage

// File: rtl/sdma_rst_sync.sv
module sdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  input  logic              busy,
  input  logic              set_done_rd,
  input  logic              set_done_wr,
  input  logic              set_err_rd,
  input  logic              set_err_wr,
  output logic              go,
  output logic              mode_dir,
  output logic              mode_inc,
  output logic [ADDR_W-1:0] start_addr,
  output logic              abort_rd,
  output logic              abort_wr
);
  logic          dir_q, inc_q;
  logic [RW-1:0] lo_q, hi_q;
  logic          done_rd_q, done_wr_q, err_rd_q, err_wr_q;
  logic          done_rd_d, done_wr_d, err_rd_d, err_wr_d;
  logic          mode_en, lo_en, hi_en, done_wsel, err_wsel, rst_wsel;

  assign mode_en   = reg_we && (reg_addr == OFS_MODE);
  assign lo_en     = reg_we && (reg_addr == OFS_ADDR_LO);
  assign hi_en     = reg_we && (reg_addr == OFS_ADDR_HI);
  assign done_wsel = reg_we && (reg_addr == OFS_DONE);
  assign err_wsel  = reg_we && (reg_addr == OFS_ERR);
  assign rst_wsel  = reg_we && (reg_addr == OFS_RST);

  assign go       = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_GO_BIT] && !busy;
  assign abort_rd = rst_wsel && reg_wdata[RST_RD_BIT];
  assign abort_wr = rst_wsel && reg_wdata[RST_WR_BIT];

  always_comb begin
    done_rd_d = done_rd_q;
    done_wr_d = done_wr_q;
    err_rd_d  = err_rd_q;
    err_wr_d  = err_wr_q;
    if (done_wsel) begin
      done_rd_d = done_rd_q & reg_wdata[DONE_RD_BIT];
      done_wr_d = done_wr_q & reg_wdata[DONE_WR_BIT];
    end
    if (err_wsel) begin
      err_rd_d = err_rd_q & reg_wdata[ERR_RD_BIT];
      err_wr_d = err_wr_q & reg_wdata[ERR_WR_BIT];
    end
    if (abort_rd) begin
      done_rd_d = 1'b0;
      err_rd_d  = 1'b0;
    end
    if (abort_wr) begin
      done_wr_d = 1'b0;
      err_wr_d  = 1'b0;
    end
    if (set_done_rd) done_rd_d = 1'b1;
    if (set_done_wr) done_wr_d = 1'b1;
    if (set_err_rd)  err_rd_d  = 1'b1;
    if (set_err_wr)  err_wr_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      inc_q <= 1'b0;
    end else if (mode_en) begin
      dir_q <= reg_wdata[MODE_DIR_BIT];
      inc_q <= reg_wdata[MODE_INC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_rd_q <= 1'b0;
      done_wr_q <= 1'b0;
      err_rd_q  <= 1'b0;
      err_wr_q  <= 1'b0;
    end else begin
      done_rd_q <= done_rd_d;
      done_wr_q <= done_wr_d;
      err_rd_q  <= err_rd_d;
      err_wr_q  <= err_wr_d;
    end
  end

  assign mode_dir   = dir_q;
  assign mode_inc   = inc_q;
  assign start_addr = {hi_q, lo_q};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_MODE: begin
        reg_rdata[MODE_DIR_BIT] = dir_q;
        reg_rdata[MODE_INC_BIT] = inc_q;
      end
      OFS_CTRL: reg_rdata[CTRL_GO_BIT] = busy;
      OFS_DONE: begin
        reg_rdata[DONE_RD_BIT] = done_rd_q;
        reg_rdata[DONE_WR_BIT] = done_wr_q;
      end
      OFS_ERR: begin
        reg_rdata[ERR_RD_BIT] = err_rd_q;
        reg_rdata[ERR_WR_BIT] = err_wr_q;
      end
      OFS_ADDR_LO: reg_rdata = lo_q;
      OFS_ADDR_HI: reg_rdata = hi_q;
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdma_walker.sv
module sdma_walker
  import sdma_pkg::*;
#(
  parameter int BSZ_W = 12,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BSZ_W-1:0]  blk_size,
  input  logic [CNT_W-1:0]  blk_count,
  input  logic              load,
  input  logic              step,
  input  logic              inc,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last,
  output logic              len_zero
);
  localparam int LEN_W   = BSZ_W + CNT_W;
  localparam int WORDS_W = LEN_W - 2;

  logic [LEN_W-1:0]   bytes;
  logic [WORDS_W-1:0] words;
  logic [WORDS_W-1:0] rem_q, rem_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               cnt_en;

  assign bytes    = {{CNT_W{1'b0}}, blk_size} * {{BSZ_W{1'b0}}, blk_count};
  assign words    = bytes[LEN_W-1:2];
  assign len_zero = (words == '0);
  assign cnt_en   = load | step;

  always_comb begin
    if (load) begin
      rem_d  = words;
      addr_d = base;
    end else begin
      rem_d  = rem_q - {{(WORDS_W-1){1'b0}}, 1'b1};
      addr_d = addr_q + {{(ADDR_W-3){1'b0}}, inc, 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      addr_q <= '0;
    end else if (cnt_en) begin
      rem_q  <= rem_d;
      addr_q <= addr_d;
    end
  end

  assign cur_addr = addr_q;
  assign last     = (rem_q == {{(WORDS_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/sdma_fsm.sv
module sdma_fsm
  import sdma_pkg::*;
#(
  parameter int ALIGN_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              mode_dir,
  input  logic              mode_inc,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              len_zero,
  input  logic              last,
  input  logic              abort_rd,
  input  logic              abort_wr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [RW-1:0]     mem_rdata,
  input  logic              mem_err,
  input  logic              buf_rd_valid,
  input  logic [RW-1:0]     buf_rd_data,
  input  logic              buf_wr_ready,
  output logic              busy,
  output logic              load,
  output logic              step,
  output logic              xinc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [RW-1:0]     data,
  output logic              buf_rd_pop,
  output logic              buf_wr_push,
  output logic              set_done_rd,
  output logic              set_done_wr,
  output logic              set_err_rd,
  output logic              set_err_wr
);
  localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

  xfer_st_e      st_q, st_d;
  logic          xdir_q, xdir_d, xinc_q, xinc_d, mode_en;
  logic [RW-1:0] data_q, data_d;
  logic          data_en, misaligned, abort_hit;

  assign misaligned = (start_addr[ALIGN_LSB-1:0] != '0);
  assign busy       = (st_q != ST_IDLE);
  assign abort_hit  = busy && ((abort_rd && xdir_q) || (abort_wr && !xdir_q));
  assign mode_en    = go;

  always_comb begin
    st_d        = st_q;
    xdir_d      = mode_dir;
    xinc_d      = mode_inc;
    data_d      = data_q;
    data_en     = 1'b0;
    load        = 1'b0;
    step        = 1'b0;
    buf_rd_pop  = 1'b0;
    buf_wr_push = 1'b0;
    set_done_rd = 1'b0;
    set_done_wr = 1'b0;
    set_err_rd  = 1'b0;
    set_err_wr  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (go) begin
          if (misaligned) begin
            set_err_rd = mode_dir;
            set_err_wr = !mode_dir;
          end else if (len_zero) begin
            set_done_rd = mode_dir;
            set_done_wr = !mode_dir;
          end else begin
            load = 1'b1;
            st_d = mode_dir ? ST_FETCH : ST_MREQ;
          end
        end
      end
      ST_FETCH: begin
        if (buf_rd_valid) begin
          buf_rd_pop = 1'b1;
          data_en    = 1'b1;
          data_d     = buf_rd_data;
          st_d       = ST_MREQ;
        end
      end
      ST_MREQ: begin
        if (mem_gnt) st_d = ST_MRSP;
      end
      ST_MRSP: begin
        if (mem_rvalid) begin
          if (mem_err) begin
            set_err_rd = xdir_q;
            set_err_wr = !xdir_q;
            st_d       = ST_IDLE;
          end else if (xdir_q) begin
            step = 1'b1;
            if (last) begin
              set_done_rd = 1'b1;
              st_d        = ST_IDLE;
            end else begin
              st_d = ST_FETCH;
            end
          end else begin
            data_en = 1'b1;
            data_d  = mem_rdata;
            st_d    = ST_PUSH;
          end
        end
      end
      ST_PUSH: begin
        if (buf_wr_ready) begin
          buf_wr_push = 1'b1;
          step        = 1'b1;
          if (last) begin
            set_done_wr = 1'b1;
            st_d        = ST_IDLE;
          end else begin
            st_d = ST_MREQ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (abort_hit) begin
      st_d        = ST_IDLE;
      data_en     = 1'b0;
      step        = 1'b0;
      buf_rd_pop  = 1'b0;
      buf_wr_push = 1'b0;
      set_done_rd = 1'b0;
      set_done_wr = 1'b0;
      set_err_rd  = 1'b0;
      set_err_wr  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xdir_q <= 1'b0;
      xinc_q <= 1'b0;
    end else if (mode_en) begin
      xdir_q <= xdir_d;
      xinc_q <= xinc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign xinc    = xinc_q;
  assign mem_req = (st_q == ST_MREQ);
  assign mem_we  = (st_q == ST_MREQ) && xdir_q;
  assign data    = data_q;
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int BSZ_W       = 12,
  parameter int CNT_W       = 16,
  parameter int ALIGN_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  input  logic [BSZ_W-1:0]  blk_size,
  input  logic [CNT_W-1:0]  blk_count,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [RW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [RW-1:0]     mem_rdata,
  input  logic              mem_err,
  input  logic              buf_rd_valid,
  input  logic [RW-1:0]     buf_rd_data,
  output logic              buf_rd_pop,
  input  logic              buf_wr_ready,
  output logic [RW-1:0]     buf_wr_data,
  output logic              buf_wr_push
);
  logic              rst_n_s;
  logic              busy, go, mode_dir, mode_inc, abort_rd, abort_wr;
  logic              set_done_rd, set_done_wr, set_err_rd, set_err_wr;
  logic              load, step, xinc, last, len_zero;
  logic [ADDR_W-1:0] start_addr, cur_addr;
  logic [RW-1:0]     data;

  sdma_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sdma_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .busy        (busy),
    .set_done_rd (set_done_rd),
    .set_done_wr (set_done_wr),
    .set_err_rd  (set_err_rd),
    .set_err_wr  (set_err_wr),
    .go          (go),
    .mode_dir    (mode_dir),
    .mode_inc    (mode_inc),
    .start_addr  (start_addr),
    .abort_rd    (abort_rd),
    .abort_wr    (abort_wr)
  );

  sdma_walker #(.BSZ_W(BSZ_W), .CNT_W(CNT_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .blk_size  (blk_size),
    .blk_count (blk_count),
    .load      (load),
    .step      (step),
    .inc       (xinc),
    .base      (start_addr),
    .cur_addr  (cur_addr),
    .last      (last),
    .len_zero  (len_zero)
  );

  sdma_fsm #(.ALIGN_BYTES(ALIGN_BYTES)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .go           (go),
    .mode_dir     (mode_dir),
    .mode_inc     (mode_inc),
    .start_addr   (start_addr),
    .len_zero     (len_zero),
    .last         (last),
    .abort_rd     (abort_rd),
    .abort_wr     (abort_wr),
    .mem_gnt      (mem_gnt),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .mem_err      (mem_err),
    .buf_rd_valid (buf_rd_valid),
    .buf_rd_data  (buf_rd_data),
    .buf_wr_ready (buf_wr_ready),
    .busy         (busy),
    .load         (load),
    .step         (step),
    .xinc         (xinc),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .data         (data),
    .buf_rd_pop   (buf_rd_pop),
    .buf_wr_push  (buf_wr_push),
    .set_done_rd  (set_done_rd),
    .set_done_wr  (set_done_wr),
    .set_err_rd   (set_err_rd),
    .set_err_wr   (set_err_wr)
  );

  assign mem_addr    = cur_addr;
  assign mem_wdata   = data;
  assign buf_wr_data = data;
endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk #(
  parameter int ADDR_W    = 64,
  parameter int ALIGN_LSB = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              buf_rd_pop,
  input logic              buf_rd_valid,
  input logic              buf_wr_push,
  input logic              buf_wr_ready,
  input logic              busy,
  input logic              go,
  input logic [ADDR_W-1:0] start_addr,
  input logic              set_done_rd,
  input logic              set_done_wr,
  input logic              set_err_rd,
  input logic              set_err_wr
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11

  AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_pop |-> buf_rd_valid); // R3

  AST_PUSH_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_push |-> buf_wr_ready); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !buf_rd_pop && !buf_wr_push); // R1

  AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go)); // R2

  AST_ERR_EXCLUDES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_done_rd && set_err_rd) && !(set_done_wr && set_err_wr)); // R8

  AST_MISALIGN_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    go && (start_addr[ALIGN_LSB-1:0] != '0) |=> !busy); // R7
endmodule

bind sdma_engine sdma_engine_chk #(.ADDR_W(64), .ALIGN_LSB(4)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req      (mem_req),
  .mem_gnt      (mem_gnt),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .buf_rd_pop   (buf_rd_pop),
  .buf_rd_valid (buf_rd_valid),
  .buf_wr_push  (buf_wr_push),
  .buf_wr_ready (buf_wr_ready),
  .busy         (busy),
  .go           (go),
  .start_addr   (start_addr),
  .set_done_rd  (set_done_rd),
  .set_done_wr  (set_done_wr),
  .set_err_rd   (set_err_rd),
  .set_err_wr   (set_err_wr)
);

// File: tb/tb_sdma_engine.sv
module tb_sdma_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NLOG = 32;

  typedef struct packed {
    logic        dir;
    logic        inc;
    logic [63:0] addr;
    logic [11:0] bsz;
    logic [15:0] bcnt;
    logic        err;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b1, 64'h0000_0000_0000_1000, 12'd16, 16'd2, 1'b0},
    '{1'b0, 1'b1, 64'h0000_0000_0000_2000, 12'd8,  16'd3, 1'b0},
    '{1'b1, 1'b0, 64'h0000_0000_0000_0030, 12'd16, 16'd1, 1'b0},
    '{1'b0, 1'b0, 64'h0000_0000_0000_0040, 12'd4,  16'd2, 1'b0},
    '{1'b1, 1'b1, 64'h0000_0001_FFFF_FFF0, 12'd32, 16'd1, 1'b0},
    '{1'b1, 1'b1, 64'h0000_0000_0000_1004, 12'd16, 16'd1, 1'b1},
    '{1'b0, 1'b1, 64'h0000_0000_0000_0008, 12'd16, 16'd1, 1'b1},
    '{1'b0, 1'b1, 64'h0000_0000_0000_0080, 12'd16, 16'd0, 1'b0}
  };

  logic        clk, rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [11:0] blk_size;
  logic [15:0] blk_count;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid, mem_err;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        buf_rd_valid, buf_rd_pop, buf_wr_ready, buf_wr_push;
  logic [31:0] buf_rd_data, buf_wr_data;

  logic        clr_logs, gnt_slow, src_en, snk_en;
  int          err_beat;
  int          cyc, mem_n, src_idx, snk_n;
  logic [63:0] log_addr  [NLOG];
  logic [31:0] log_wdata [NLOG];
  logic        log_we    [NLOG];
  logic [31:0] snk_log   [NLOG];
  int          total, bad;
  logic [31:0] rv;

  sdma_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blk_size(blk_size),
    .blk_count(blk_count), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .buf_rd_valid(buf_rd_valid), .buf_rd_data(buf_rd_data),
    .buf_rd_pop(buf_rd_pop), .buf_wr_ready(buf_wr_ready),
    .buf_wr_data(buf_wr_data), .buf_wr_push(buf_wr_push)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_gnt      = mem_req && (!gnt_slow || cyc[0]);
  assign buf_rd_valid = src_en;
  assign buf_rd_data  = 32'hA500_0000 | src_idx;
  assign buf_wr_ready = snk_en;

  always @(posedge clk) begin
    cyc        <= cyc + 1;
    mem_rvalid <= 1'b0;
    mem_err    <= 1'b0;
    if (clr_logs) begin
      mem_n   <= 0;
      src_idx <= 0;
      snk_n   <= 0;
    end else begin
      if (mem_req && mem_gnt) begin
        if (mem_n < NLOG) begin
          log_addr[mem_n]  <= mem_addr;
          log_wdata[mem_n] <= mem_wdata;
          log_we[mem_n]    <= mem_we;
        end
        mem_rvalid <= 1'b1;
        mem_rdata  <= 32'hC300_0000 | mem_n;
        mem_err    <= (mem_n == err_beat);
        mem_n      <= mem_n + 1;
      end
      if (buf_rd_pop) src_idx <= src_idx + 1;
      if (buf_wr_push) begin
        if (snk_n < NLOG) snk_log[snk_n] <= buf_wr_data;
        snk_n <= snk_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_logs();
    @(negedge clk); clr_logs = 1'b1;
    @(negedge clk); clr_logs = 1'b0;
  endtask

  task automatic start_xfer(input logic dir, input logic inc, input logic [63:0] a,
                            input logic [11:0] bsz, input logic [15:0] bcnt, input bit clear);
    blk_size  = bsz;
    blk_count = bcnt;
    wr(3'd0, {15'd0, dir, 15'd0, inc});
    wr(3'd5, a[31:0]);
    wr(3'd6, a[63:32]);
    if (clear) begin
      wr(3'd3, 32'd0);
      wr(3'd4, 32'd0);
    end
    clear_logs();
    wr(3'd1, 32'd1);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, v);
      if (v == 32'd0) break;
    end
  endtask

  function automatic string vtag(input int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R5";
      4: return "R12";
      5: return "R7";
      6: return "R7";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    blk_size = '0; blk_count = '0;
    clr_logs = 1'b0; gnt_slow = 1'b0; src_en = 1'b1; snk_en = 1'b1;
    err_beat = -1; cyc = 0; mem_n = 0; src_idx = 0; snk_n = 0;
    mem_rvalid = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(a[2:0], rv);
      chk(rv == 32'd0, "R1 reg", {32'd0, rv}, 64'd0);
    end
    chk(!mem_req && !buf_rd_pop && !buf_wr_push, "R1 idle outputs",
        {63'd0, mem_req | buf_rd_pop | buf_wr_push}, 64'd0);

    // table of vectors
    for (int i = 0; i < 8; i++) begin
      int exp_n, amis, dmis, wemis;
      vec_t v;
      v = VECS[i];
      exp_n = v.err ? 0 : (int'(v.bsz) * int'(v.bcnt)) / 4;
      gnt_slow = (i % 2 == 1);
      start_xfer(v.dir, v.inc, v.addr, v.bsz, v.bcnt, 1'b1);
      wait_idle();
      chk(mem_n == exp_n, {vtag(i), " beats"}, 64'(mem_n), 64'(exp_n));
      amis = 0; dmis = 0; wemis = 0;
      for (int k = 0; k < exp_n && k < NLOG; k++) begin
        if (log_addr[k] != (v.inc ? v.addr + 64'(4 * k) : v.addr)) amis++;
        if (log_we[k] != v.dir) wemis++;
        if (v.dir && log_wdata[k] != (32'hA500_0000 | k)) dmis++;
        if (!v.dir && snk_log[k] != (32'hC300_0000 | k)) dmis++;
      end
      chk(amis == 0, {vtag(i), " addresses"}, 64'(amis), 64'd0);
      chk(wemis == 0 && dmis == 0, {vtag(i), " data"}, 64'(wemis + dmis), 64'd0);
      if (!v.dir) chk(snk_n == exp_n, {vtag(i), " pushes"}, 64'(snk_n), 64'(exp_n));
      rd(3'd3, rv);
      chk(rv == (v.err ? 32'd0 : (v.dir ? 32'h0010_0000 : 32'h0001_0000)),
          {vtag(i), " done flags"}, {32'd0, rv},
          {32'd0, (v.err ? 32'd0 : (v.dir ? 32'h0010_0000 : 32'h0001_0000))});
      rd(3'd4, rv);
      chk(rv == (v.err ? (v.dir ? 32'h0002_0000 : 32'h0001_0000) : 32'd0),
          {vtag(i), " err flags"}, {32'd0, rv},
          {32'd0, (v.err ? (v.dir ? 32'h0002_0000 : 32'h0001_0000) : 32'd0)});
    end
    gnt_slow = 1'b0;

    // R8 memory error mid-transfer
    err_beat = 3;
    start_xfer(1'b1, 1'b1, 64'h100, 12'd32, 16'd1, 1'b1);
    wait_idle();
    err_beat = -1;
    chk(mem_n == 4, "R8 beats before stop", 64'(mem_n), 64'd4);
    chk(src_idx == 4, "R8 pops before stop", 64'(src_idx), 64'd4);
    rd(3'd4, rv); chk(rv == 32'h0002_0000, "R8 err flag", {32'd0, rv}, 64'h2_0000);
    rd(3'd3, rv); chk(rv == 32'd0, "R8 no done", {32'd0, rv}, 64'd0);

    // R9 write-zero-to-clear
    start_xfer(1'b0, 1'b1, 64'h18, 12'd4, 16'd1, 1'b0);
    wait_idle();
    rd(3'd4, rv); chk(rv == 32'h0003_0000, "R9 both errs", {32'd0, rv}, 64'h3_0000);
    wr(3'd4, 32'h0002_0000);
    rd(3'd4, rv); chk(rv == 32'h0002_0000, "R9 keep one", {32'd0, rv}, 64'h2_0000);
    wr(3'd4, 32'd0);
    rd(3'd4, rv); chk(rv == 32'd0, "R9 clear all", {32'd0, rv}, 64'd0);

    // R2 busy reads 1, second start ignored
    gnt_slow = 1'b1;
    start_xfer(1'b1, 1'b1, 64'h200, 12'd16, 16'd1, 1'b1);
    rd(3'd1, rv); chk(rv == 32'd1, "R2 busy bit", {32'd0, rv}, 64'd1);
    wr(3'd5, 32'h300);
    wr(3'd1, 32'd1);
    wait_idle();
    gnt_slow = 1'b0;
    chk(mem_n == 4, "R2 restart ignored beats", 64'(mem_n), 64'd4);
    chk(log_addr[3] == 64'h20C, "R2 restart ignored addr", log_addr[3], 64'h20C);
    rd(3'd1, rv); chk(rv == 32'd0, "R2 self clear", {32'd0, rv}, 64'd0);

    // R10 abort card-to-memory side
    src_en = 1'b0;
    start_xfer(1'b1, 1'b1, 64'h400, 12'd16, 16'd1, 1'b1);
    repeat (4) @(posedge clk);
    wr(3'd2, 32'h0000_0100);
    rd(3'd1, rv); chk(rv == 32'd1, "R10 other side ignored", {32'd0, rv}, 64'd1);
    wr(3'd2, 32'h0000_0200);
    rd(3'd1, rv); chk(rv == 32'd0, "R10 rd abort stops", {32'd0, rv}, 64'd0);
    src_en = 1'b1;
    repeat (5) @(posedge clk);
    chk(mem_n == 0 && src_idx == 0, "R10 no beats after abort",
        64'(mem_n + src_idx), 64'd0);

    // R10 abort memory-to-card side clears its done flag
    start_xfer(1'b0, 1'b1, 64'h480, 12'd4, 16'd1, 1'b1);
    wait_idle();
    snk_en = 1'b0;
    start_xfer(1'b0, 1'b1, 64'h500, 12'd8, 16'd1, 1'b0);
    repeat (6) @(posedge clk);
    wr(3'd2, 32'h0000_0100);
    rd(3'd1, rv); chk(rv == 32'd0, "R10 wr abort stops", {32'd0, rv}, 64'd0);
    rd(3'd3, rv); chk(rv == 32'd0, "R10 wr flag cleared", {32'd0, rv}, 64'd0);
    snk_en = 1'b1;
    repeat (5) @(posedge clk);
    chk(snk_n == 0, "R10 no push after abort", 64'(snk_n), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule